// File: doc/BRIEF.md
# Saturating Mixed-Sign Byte Dot-Product Accumulator

This block is a vector datapath for low-precision inference kernels. It splits each operand vector into 32-bit lanes. In every lane it multiplies four unsigned bytes of operand A by the four signed bytes at the same positions in operand B. It adds the four products together and adds that total to the matching lane of an accumulator vector. The lane result is clamped to the signed 32-bit range and does not wrap.

A per-lane mask chooses which lanes take the new value. For a lane whose mask bit is clear, a mode input decides the output: either the accumulator lane passes through unchanged, or the lane is forced to zero. The lane count is a parameter and may be 4, 8 or 16. The mask port is 8 bits wide for up to 8 lanes and 16 bits wide for 16 lanes. The result is registered, so it appears one clock after the input strobe, together with a valid flag.

Top module: `byte_dot_acc`

## Requirements
- R1: Lane i takes bytes 4i, 4i+1, 4i+2 and 4i+3 of both A and B, with byte k at bits 8k+7..8k of the vector. Each A byte is read as unsigned (0..255) and each B byte as signed two's complement (-128..127), and the four products are formed exactly.
- R2: For a selected lane, the output is the signed 32-bit accumulator lane plus the exact four-product sum, whenever that total fits in the signed 32-bit range.
- R3: When the exact total exceeds 2^31-1, the lane outputs 0x7FFFFFFF.
- R4: When the exact total is below -2^31, the lane outputs 0x80000000. A total of exactly -2^31 is not clamped.
- R5: With zero_mode = 0, a lane whose mask bit is 0 outputs its accumulator lane unchanged.
- R6: With zero_mode = 1, a lane whose mask bit is 0 outputs zero.
- R7: An all-ones mask gives the unmasked result in every lane, whatever the value of zero_mode.
- R8: Lanes are independent. Mask bit i governs only lane i, and mask bits at or above LANES have no effect.
- R9: out_valid is high in the cycle after a cycle with in_valid high, and low otherwise. result updates only when in_valid is high and holds its value otherwise.
- R10: While rst_n is low at a clock edge, out_valid and result are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| acc_in | input | 32*LANES | Signed 32-bit accumulator lanes |
| opa | input | 32*LANES | Unsigned byte operand vector |
| opb | input | 32*LANES | Signed byte operand vector |
| lane_mask | input | 8 or 16 | Per-lane select, bit i for lane i |
| zero_mode | input | 1 | 0 = masked lanes keep accumulator, 1 = masked lanes give zero |
| out_valid | output | 1 | Result registered from the previous cycle's inputs |
| result | output | 32*LANES | Registered result lanes |

## Verification
A hand-built lane with mixed-sign bytes and known products separates unsigned from signed byte handling, and it also catches a wrong byte position. Operand extremes are driven with the accumulator near either limit, including the exact -2^31 landing point. These cases tell a correct clamp from wrap-around, and from a clamp applied one count early or to the wrong side. Alternating masks in both modes, plus masks that differ only above the lane count, tell merge masking from zero masking and expose cross-lane mask decoding. Long runs of seeded random vectors, with random masks and modes, exercise the ordinary unsaturated accumulate, and idle cycles with changing inputs probe the hold behaviour.

// File: rtl/dpacc_pkg.sv
// Shared constants for the byte dot-product accumulator.
// Assumes four bytes per 32-bit lane.
package dpacc_pkg;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_LANE = 4;
    localparam int LANE_W         = BYTE_W * BYTES_PER_LANE;
    // unsigned byte (zero-extended to 9 bits) times signed byte
    localparam int PROD_W         = 2 * BYTE_W + 1;
    localparam int SUM_W          = PROD_W + $clog2(BYTES_PER_LANE);
endpackage

// File: rtl/lane_dot4.sv
// Computes the exact sum of NBYTES products of an unsigned byte of A and a
// signed byte of B for one lane. Assumes SUM_W is wide enough for the worst
// case, so no intermediate term saturates or wraps.
module lane_dot4 #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4,
    parameter int PROD_W = 2 * BYTE_W + 1,
    parameter int SUM_W  = PROD_W + $clog2(NBYTES)
) (
    input  logic [NBYTES*BYTE_W-1:0] a_bytes,
    input  logic [NBYTES*BYTE_W-1:0] b_bytes,
    output logic signed [SUM_W-1:0]  dot
);
    logic signed [PROD_W-1:0] prod [NBYTES];

    for (genvar k = 0; k < NBYTES; k++) begin : g_prod
        logic signed [BYTE_W:0]   ua;
        logic signed [BYTE_W-1:0] sb;
        assign ua      = {1'b0, a_bytes[k*BYTE_W +: BYTE_W]};
        assign sb      = b_bytes[k*BYTE_W +: BYTE_W];
        assign prod[k] = PROD_W'(ua) * PROD_W'(sb);
    end

    // Adds the sign-extended products into one exact total.
    always_comb begin
        dot = '0;
        for (int k = 0; k < NBYTES; k++)
            dot = dot + SUM_W'(prod[k]);
    end
endmodule

// File: rtl/lane_sat_add.sv
// Adds a signed dot-product total to a signed accumulator lane and clamps
// to the signed LANE_W range. Assumes SUM_W <= LANE_W.
module lane_sat_add #(
    parameter int LANE_W = 32,
    parameter int SUM_W  = 19
) (
    input  logic signed [LANE_W-1:0] acc,
    input  logic signed [SUM_W-1:0]  dot,
    output logic signed [LANE_W-1:0] res
);
    localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};

    logic signed [LANE_W-1:0] dot_x;
    logic signed [LANE_W-1:0] wrapped;
    logic                     ovf;

    assign dot_x = LANE_W'(dot);

    // Forms the wrapped sum and detects a sign flip between like-signed operands.
    always_comb begin
        wrapped = acc + dot_x;
        ovf     = (acc[LANE_W-1] == dot_x[LANE_W-1]) &&
                  (wrapped[LANE_W-1] != acc[LANE_W-1]);
        res     = ovf ? (POS_LIM + LANE_W'(dot_x[LANE_W-1])) : wrapped;
    end

    // Two non-negative operands never give a negative lane, and vice versa.
    always_comb begin
        if (!acc[LANE_W-1] && !dot[SUM_W-1])
            p_no_overflow_r3: assert (!res[LANE_W-1]);
        if (acc[LANE_W-1] && dot[SUM_W-1])
            p_no_underflow_r4: assert (res[LANE_W-1]);
    end
endmodule

// File: rtl/byte_dot_acc.sv
// Vector of LANES independent 32-bit lanes. Each lane accumulates a
// saturating unsigned-by-signed byte dot product, then applies merge or zero
// masking, and the result is registered one cycle after in_valid.
// Assumes LANES is 4, 8 or 16; mask bits at or above LANES are ignored.
module byte_dot_acc
    import dpacc_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VEC_W  = LANES * LANE_W,
    localparam int MASK_W = (LANES <= 8) ? 8 : 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  acc_in,
    input  logic [VEC_W-1:0]  opa,
    input  logic [VEC_W-1:0]  opb,
    input  logic [MASK_W-1:0] lane_mask,
    input  logic              zero_mode,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);
    logic [VEC_W-1:0] lane_next;
    logic             unused_mask_hi;

    assign unused_mask_hi = ^lane_mask;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [SUM_W-1:0]  dot;
        logic signed [LANE_W-1:0] sat;
        logic        [LANE_W-1:0] sel;

        lane_dot4 #(
            .BYTE_W (BYTE_W),
            .NBYTES (BYTES_PER_LANE),
            .PROD_W (PROD_W),
            .SUM_W  (SUM_W)
        ) i_dot (
            .a_bytes (opa[i*LANE_W +: LANE_W]),
            .b_bytes (opb[i*LANE_W +: LANE_W]),
            .dot     (dot)
        );

        lane_sat_add #(
            .LANE_W (LANE_W),
            .SUM_W  (SUM_W)
        ) i_sat (
            .acc (acc_in[i*LANE_W +: LANE_W]),
            .dot (dot),
            .res (sat)
        );

        // Picks the new value, the old accumulator, or zero for this lane.
        always_comb begin
            if (lane_mask[i])   sel = sat;
            else if (zero_mode) sel = '0;
            else                sel = acc_in[i*LANE_W +: LANE_W];
        end

        assign lane_next[i*LANE_W +: LANE_W] = sel;

        // R6: a masked lane in zero mode is zero on the next cycle.
        p_zero_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && zero_mode && !lane_mask[i]) |=> (result[i*LANE_W +: LANE_W] == '0));

        // R5: a masked lane in merge mode returns its accumulator input.
        p_merge_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !zero_mode && !lane_mask[i]) |=>
            (result[i*LANE_W +: LANE_W] == $past(acc_in[i*LANE_W +: LANE_W])));
    end

    // Registers the lane vector and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= lane_next;
        end
    end

    // R9: valid follows the strobe by one cycle.
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: result holds without a strobe.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R10: reset clears the outputs.
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

// File: tb/test_byte_dot_acc.sv
`timescale 1ns/1ps
module test_byte_dot_acc;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANES * 32;
    localparam int MASK_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [VEC_W-1:0]  acc_in = '0;
    logic [VEC_W-1:0]  opa = '0;
    logic [VEC_W-1:0]  opb = '0;
    logic [MASK_W-1:0] lane_mask = '0;
    logic              zero_mode = 1'b0;
    logic              out_valid;
    logic [VEC_W-1:0]  result;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    byte_dot_acc #(.LANES(LANES)) i_byte_dot_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
        .opa(opa), .opb(opb), .lane_mask(lane_mask), .zero_mode(zero_mode),
        .out_valid(out_valid), .result(result)
    );

    // Reference for one lane, computed with wide arithmetic and clamping.
    function automatic logic [31:0] ref_lane(input logic [31:0] acc, input logic [31:0] a,
                                             input logic [31:0] b, input bit sel, input bit zm);
        longint s;
        if (!sel) return zm ? 32'h0 : acc;
        s = longint'($signed(acc));
        for (int k = 0; k < 4; k++)
            s = s + longint'({1'b0, a[8*k +: 8]}) * longint'($signed(b[8*k +: 8]));
        if (s > 64'sd2147483647)  return 32'h7FFF_FFFF;
        if (s < -64'sd2147483648) return 32'h8000_0000;
        return s[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Applies one strobe at a falling edge and compares every lane after capture.
    task automatic apply(input string req, input logic [VEC_W-1:0] acc,
                         input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                         input logic [MASK_W-1:0] m, input bit zm);
        logic [VEC_W-1:0] exp;
        for (int i = 0; i < LANES; i++)
            exp[32*i +: 32] = ref_lane(acc[32*i +: 32], a[32*i +: 32], b[32*i +: 32], m[i], zm);
        acc_in = acc; opa = a; opb = b; lane_mask = m; zero_mode = zm; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R9 valid"}, {31'b0, out_valid}, 32'd1);
        for (int i = 0; i < LANES; i++)
            check(req, result[32*i +: 32], exp[32*i +: 32]);
    endtask

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int i = 0; i < LANES; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VEC_W-1:0] fill(input logic [31:0] w);
        return {LANES{w}};
    endfunction

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [VEC_W-1:0] hold_val;
        logic [VEC_W-1:0] va, vb, vc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset valid", {31'b0, out_valid}, 32'd0);
        check("R10 reset result", result[31:0], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: hand-built lane 0 with mixed signs: 1-2+6-8 = -3, +100 = 97
        va = rnd_vec(); vb = rnd_vec(); vc = rnd_vec();
        va[31:0] = 32'h0403_0201; vb[31:0] = 32'hFE02_FF01; vc[31:0] = 32'd100;
        apply("R1", vc, va, vb, 8'hFF, 1'b0);
        check("R1 literal", result[31:0], 32'd97);

        // R3: positive overflow
        apply("R3", fill(32'h7FFF_FFF0), fill(32'hFFFF_FFFF), fill(32'h7F7F_7F7F), 8'hFF, 1'b0);
        check("R3 literal", result[31:0], 32'h7FFF_FFFF);
        // R4: negative overflow
        apply("R4", fill(32'h8000_0010), fill(32'hFFFF_FFFF), fill(32'h8080_8080), 8'hFF, 1'b1);
        check("R4 literal", result[31:0], 32'h8000_0000);
        // R4: landing exactly on -2^31 (sum -130560) is not clamped
        apply("R4 edge", fill(32'h8001_FE00), fill(32'hFFFF_FFFF), fill(32'h8080_8080), 8'hFF, 1'b0);
        check("R4 edge literal", result[63:32], 32'h8000_0000);

        // R5: merge masking
        vc = rnd_vec();
        apply("R5", vc, rnd_vec(), rnd_vec(), 8'b0000_0101, 1'b0);
        check("R5 literal", result[63:32], vc[63:32]);
        // R6: zero masking
        apply("R6", rnd_vec(), rnd_vec(), rnd_vec(), 8'b0000_0110, 1'b1);
        check("R6 literal", result[31:0], 32'd0);

        // R7: all-ones mask in both modes gives the same plain result
        va = rnd_vec(); vb = rnd_vec(); vc = rnd_vec();
        apply("R7 mode0", vc, va, vb, 8'hFF, 1'b0);
        hold_val = result;
        apply("R7 mode1", vc, va, vb, 8'hFF, 1'b1);
        for (int i = 0; i < LANES; i++) check("R7 same", result[32*i +: 32], hold_val[32*i +: 32]);

        // R8: mask bits above LANES have no effect
        apply("R8 hi", vc, va, vb, 8'h0F, 1'b1);
        for (int i = 0; i < LANES; i++) check("R8 hi", result[32*i +: 32], hold_val[32*i +: 32]);
        apply("R8 lane", vc, va, vb, 8'hF8, 1'b1);

        // R9: idle cycles with changing inputs leave result unchanged
        hold_val = result;
        for (int n = 0; n < 4; n++) begin
            acc_in = rnd_vec(); opa = rnd_vec(); opb = rnd_vec(); lane_mask = 8'($urandom);
            @(negedge clk);
            check("R9 idle valid", {31'b0, out_valid}, 32'd0);
            for (int i = 0; i < LANES; i++) check("R9 hold", result[32*i +: 32], hold_val[32*i +: 32]);
        end

        // R2: random vectors with random masks and modes; some near the limits
        for (int n = 0; n < 400; n++) begin
            vc = rnd_vec();
            if (n % 5 == 0) vc = fill(32'h7FFF_0000 + ($urandom % 32'h20000));
            if (n % 7 == 0) vc = fill(32'h8000_0000 + ($urandom % 32'h20000));
            apply("R2", vc, rnd_vec(), rnd_vec(), 8'($urandom), 1'($urandom));
        end

        // R10: reset in the middle of operation
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 mid valid", {31'b0, out_valid}, 32'd0);
        for (int i = 0; i < LANES; i++) check("R10 mid result", result[32*i +: 32], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule